// File: doc/BRIEF.md
# Card Serial Clock Divider

This block derives the serial clock for an SD/MMC card from a fast host clock. An 8-bit divide setting picks the ratio. A setting of zero halves the host clock. Any other setting N divides the host clock by 4·N, so the high and low phases each last 2·N host cycles. Alongside the card clock the block raises two one-cycle strobes. One comes just before each rising transition and the other just before each falling transition, so a command or data shifter running on the host clock can launch or capture bits at the right moment.

Software clears the serial-interface enable, sets the new divide value and clock-source choice, and then sets the enable again. The block captures the divide value and the source choice only in the cycle where it sees the enable go from low to high, so a value that changes while the enable is set cannot shorten a phase.

The source select works as follows. With it cleared, the block divides the host clock. With it set, the card clock is expected to come from a source outside this block, so the block's own output stays low.

Top module: `card_sclk_gen`

## Requirements
- R1: With a captured divide value of 0, the card clock toggles every host cycle, giving a period of 2 host cycles.
- R2: With a captured divide value N from 1 to 255, the card clock has a period of 4·N host cycles, with exactly 2·N cycles high and 2·N cycles low.
- R3: While the enable input is low, the card clock is low from the first host edge that samples the low enable, and neither strobe is asserted.
- R4: The divide value and the source select are captured only in the cycle where the enable goes from low to high. Changes to either while the enable stays high have no effect on the output.
- R5: After the capture cycle the card clock starts low. Its first rising transition comes after one half period: 1 host cycle for a divide value of 0, otherwise 2·N cycles.
- R6: The rise strobe is high for exactly one host cycle, the cycle just before each low-to-high card clock transition. The fall strobe does the same before each high-to-low transition. The two strobes are never high together.
- R7: With the source select captured as 1 (alternate source), the card clock stays low and no strobes are produced. With it captured as 0, the host clock is divided.
- R8: During and right after reset, the card clock and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_val | input | 8 | Divide setting (0: host/2, N: host/(4·N)) |
| ser_en | input | 1 | Serial interface enable; a rising level captures the setting |
| src_sel | input | 1 | Clock source choice: 0 host clock, 1 alternate source (output held low) |
| sclk_o | output | 1 | Card serial clock |
| rise_stb_o | output | 1 | One-cycle strobe before each rising card clock transition |
| fall_stb_o | output | 1 | One-cycle strobe before each falling card clock transition |

## Verification
The host edge that first samples a high enable captures the setting. The cycle after that edge is index 0 of the run, and the first rise strobe falls on index H−1, where H is the half period. Each card clock transition lands one cycle after its strobe. After the enable drops, the card clock is low again one edge later. The bench drives inputs one nanosecond after each falling edge and compares on the falling edge against a model that counts cycles since capture with integer division. This keeps every comparison in the cycle where the result is due. Explicit checks over windows of eight periods then confirm the period, the duty cycle and the index of the first rise strobe for each setting.

// File: rtl/card_sclk_gen.sv
module card_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             ser_en,
  input  logic             src_sel,
  output logic             sclk_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o
);

  localparam int CNT_W = DIV_W + 1;

  logic [DIV_W-1:0] div_q;
  logic             src_q;
  logic             en_d;
  logic             sclk_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half;
  logic             run;
  logic             wrap;

  assign half       = (div_q == '0) ? CNT_W'(1) : {div_q, 1'b0};
  assign run        = en_d & ser_en & ~src_q;
  assign wrap       = run & (cnt == half - 1'b1);
  assign rise_stb_o = wrap & ~sclk_q;
  assign fall_stb_o = wrap & sclk_q;
  assign sclk_o     = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      src_q  <= 1'b0;
      en_d   <= 1'b0;
      sclk_q <= 1'b0;
      cnt    <= '0;
    end else begin
      en_d <= ser_en;
      if (ser_en && !en_d) begin
        div_q  <= div_val;
        src_q  <= src_sel;
        cnt    <= '0;
        sclk_q <= 1'b0;
      end else if (run) begin
        if (wrap) begin
          cnt    <= '0;
          sclk_q <= ~sclk_q;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt    <= '0;
        sclk_q <= 1'b0;
      end
    end
  end

  // R6: strobes precede the matching transition and never overlap
  a_r6_rise_then_up: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb_o |=> $rose(sclk_o));
  a_r6_fall_then_down: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb_o |=> $fell(sclk_o));
  a_r6_up_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $past(rise_stb_o));
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb_o && fall_stb_o));
  // R3: idle enable forces the clock low and silences strobes
  a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |=> !sclk_o);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en |-> !(rise_stb_o || fall_stb_o));
  // R4: captured setting holds while the enable stays high
  a_r4_hold_setting: assert property (@(posedge clk) disable iff (!rst_n)
    (en_d && ser_en) |=> ($stable(div_q) && $stable(src_q)));
  // R7: alternate source keeps the output low
  a_r7_alt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    src_q |-> !(rise_stb_o || fall_stb_o));
  // R2: phase counter stays inside the half period
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < half);

endmodule

// File: tb/card_sclk_gen_test.sv
module card_sclk_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] div_val = 8'd0;
  logic       ser_en = 1'b0;
  logic       src_sel = 1'b0;
  logic       sclk_o, rise_stb_o, fall_stb_o;

  int nchk = 0;
  int nfail = 0;
  string cur_req = "R8";

  always #2 clk = ~clk;

  card_sclk_gen #(.DIV_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .ser_en(ser_en),
    .src_sel(src_sel), .sclk_o(sclk_o), .rise_stb_o(rise_stb_o),
    .fall_stb_o(fall_stb_o)
  );

  // reference model: cycles since capture and captured half period
  bit m_on = 0;
  bit m_src = 0;
  int m_t = 0;
  int m_h = 1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_on = 0;
    end else if (ser_en && !m_on) begin
      m_on = 1; m_t = 0; m_src = src_sel;
      m_h = (div_val == 0) ? 1 : 2 * int'(div_val);
    end else if (ser_en) begin
      m_t = m_t + 1;
    end else begin
      m_on = 0;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    bit e_s, e_r, e_f;
    e_s = 0; e_r = 0; e_f = 0;
    if (m_on && !m_src) begin
      e_s = ((m_t / m_h) % 2) == 1;
      e_r = ((m_t % m_h) == m_h - 1) && !e_s;
      e_f = ((m_t % m_h) == m_h - 1) && e_s;
    end
    check(cur_req, "sclk", int'(sclk_o), int'(e_s));
    check(cur_req, "rise strobe", int'(rise_stb_o), int'(e_r));
    check(cur_req, "fall strobe", int'(fall_stb_o), int'(e_f));
  end

  task automatic drive_idle(int n);
    @(negedge clk); #1 ser_en = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // enable with a setting, then measure 8 periods of output
  task automatic measure(string req, int dv, bit chg);
    int h, p, rises, highs, first;
    h = (dv == 0) ? 1 : 2 * dv;
    p = 2 * h;
    rises = 0; highs = 0; first = -1;
    cur_req = req;
    @(negedge clk); #1 div_val = 8'(dv); src_sel = 1'b0; ser_en = 1'b1;
    for (int i = 0; i < 8 * p; i++) begin
      @(negedge clk);
      if (rise_stb_o) begin
        rises++;
        if (first < 0) first = i;
      end
      if (sclk_o) highs++;
      if (chg && i == 3) begin
        #1 div_val = 8'(dv + 3); src_sel = 1'b1;
      end
    end
    check(req, "rise count", rises, 8);
    check(req, "high cycles", highs, 4 * p);
    check("R5", "first rise index", first, h - 1);
    drive_idle(3);
  endtask

  initial begin
    int st;
    repeat (3) @(negedge clk);
    check("R8", "sclk in reset", int'(sclk_o), 0);
    check("R8", "strobes in reset", int'(rise_stb_o | fall_stb_o), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R8", "sclk after reset", int'(sclk_o), 0);

    measure("R1", 0, 0);
    measure("R2", 1, 0);
    measure("R2", 3, 0);
    measure("R6", 6, 0);
    measure("R4", 2, 1);
    measure("R2", 255, 0);

    // R3: drop enable mid high phase
    cur_req = "R3";
    @(negedge clk); #1 div_val = 8'd4; ser_en = 1'b1;
    repeat (10) @(negedge clk);
    check("R3", "sclk high before drop", int'(sclk_o), 1);
    #1 ser_en = 1'b0;
    st = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      st += int'(sclk_o) + int'(rise_stb_o) + int'(fall_stb_o);
    end
    check("R3", "activity while disabled", st, 0);

    // R7: alternate source keeps output quiet, even if select clears later
    cur_req = "R7";
    @(negedge clk); #1 div_val = 8'd1; src_sel = 1'b1; ser_en = 1'b1;
    st = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 10) begin #1 src_sel = 1'b0; end
      st += int'(sclk_o) + int'(rise_stb_o) + int'(fall_stb_o);
    end
    check("R7", "activity with alternate source", st, 0);
    drive_idle(3);
    measure("R7", 1, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule